// File: doc/BRIEF.md
# Output Window Monitor with Power-Good

This block supervises the regulated output of a switching converter. Four digitised comparator flags tell it where the output sits relative to two hysteresis bands. Each band drives one fault flag. The overvoltage fault has an upper set level and a lower release level. The undervoltage fault has a lower set level and a higher release level. Every transition of a fault flag, whether it sets or releases, must first be seen for an unbroken filter window. This keeps comparator chatter from toggling the flags.

The block also drives an active-low power-good line. Once the mode controller reports that start-up has finished and no shutdown is requested, a long qualification delay starts. When that delay expires, power-good asserts, provided neither fault is present. A fault only releases power-good. It never touches the converter itself, and power-good comes back without a new delay as soon as the fault clears. Leaving the started state, or a fault shutdown request, releases power-good at once and restarts the delay.

All timings are given in microseconds. A clock-rate parameter turns them into cycle counts, so a bench can run with short windows.

Top module: `pgw_window_mon`

## Requirements
- R1: While rst_ni is low, pg_n_o is 1 and both ov_flt_o and uv_flt_o are 0.
- R2: With ov_flt_o at 0, ov_flt_o becomes 1 after ov_above_i has been sampled high on FILT consecutive rising clock edges (FILT = FILT_US*CLK_PER_US), and not before.
- R3: A low sample of ov_above_i before the overvoltage window completes discards the count, and a new run of FILT high samples is needed.
- R4: With ov_flt_o at 1, the flag stays set while ov_below_rel_i is low, whatever ov_above_i does. It clears only after FILT consecutive high samples of ov_below_rel_i, and a low sample restarts that count.
- R5: With uv_flt_o at 0, uv_flt_o becomes 1 after uv_below_i has been sampled high on FILT consecutive edges, and a low sample restarts the count.
- R6: With uv_flt_o at 1, the flag clears only after FILT consecutive high samples of uv_above_rel_i, and a low sample restarts the count.
- R7: pg_n_o goes to 0 on the DLY-th consecutive edge at which startup_done_i=1 and fault_shdn_i=0 are sampled (DLY = PG_DELAY_US*CLK_PER_US), and stays 1 before that edge, when no fault is present.
- R8: Once the delay has expired, pg_n_o is 1 whenever ov_flt_o or uv_flt_o is 1. It returns to 0 in the same cycle the last fault clears, with no new delay.
- R9: fault_shdn_i=1 or startup_done_i=0 forces pg_n_o to 1 combinationally and discards the elapsed delay. After release, the full DLY count is needed again.
- R10: A fault present while the delay runs does not stop or restart the delay. If the fault is still present when the delay expires, pg_n_o stays 1 and then goes to 0 in the cycle the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| startup_done_i | input | 1 | Mode controller reports start-up finished and converter running |
| fault_shdn_i | input | 1 | Fault shutdown request |
| ov_above_i | input | 1 | Output above the overvoltage set level |
| ov_below_rel_i | input | 1 | Output below the overvoltage release level |
| uv_below_i | input | 1 | Output below the undervoltage set level |
| uv_above_rel_i | input | 1 | Output above the undervoltage release level |
| pg_n_o | output | 1 | Power-good, active low |
| ov_flt_o | output | 1 | Filtered overvoltage fault |
| uv_flt_o | output | 1 | Filtered undervoltage fault |

## Verification
The bench targets off-by-one errors in both counters. It samples one edge before and at the exact expiry edge. A design that counts one edge too many or too few would show the wrong flag or power-good at one of those points. It breaks filter runs with a single low sample, which catches a filter that only pauses instead of restarting. It also parks the output inside each hysteresis band, where a design that used a single threshold would drop the fault early. Finally, it applies shutdown between edges and raises a fault during the delay. A design with a registered release, or one that restarts the delay on a fault, would mis-time power-good.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned NUM_MON = 2;
  typedef enum int unsigned {
    MON_OV = 0,
    MON_UV = 1
  } mon_idx_e;
endpackage

// File: rtl/pgw_hyst_filter.sv
module pgw_hyst_filter #(
  parameter int unsigned FILT_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flt_o
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          flt_q;
  logic [CW-1:0] cnt_q;
  logic          cond;

  // condition being qualified depends on present state
  assign cond = flt_q ? clr_i : set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (!cond) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      flt_q <= ~flt_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/pgw_pg_seq.sv
module pgw_pg_seq #(
  parameter int unsigned DLY_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic startup_i,
  input  logic shdn_i,
  input  logic fault_i,
  output logic pg_n_o
);
  localparam int unsigned DW = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC);
  localparam logic [DW-1:0] LAST = DW'(DLY_CYC - 1);

  logic          en;
  logic          armed_q;
  logic [DW-1:0] cnt_q;

  assign en = startup_i & ~shdn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      if (cnt_q == LAST) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // en in the path gives an immediate release on shutdown
  assign pg_n_o = ~(armed_q & en & ~fault_i);
endmodule

// File: rtl/pgw_window_mon.sv
module pgw_window_mon
  import pgw_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 100,
  parameter int unsigned FILT_US     = 20,
  parameter int unsigned PG_DELAY_US = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic startup_done_i,
  input  logic fault_shdn_i,
  input  logic ov_above_i,
  input  logic ov_below_rel_i,
  input  logic uv_below_i,
  input  logic uv_above_rel_i,
  output logic pg_n_o,
  output logic ov_flt_o,
  output logic uv_flt_o
);
  localparam int unsigned FILT_CYC = FILT_US * CLK_PER_US;
  localparam int unsigned DLY_CYC  = PG_DELAY_US * CLK_PER_US;

  logic [NUM_MON-1:0] set_cond;
  logic [NUM_MON-1:0] clr_cond;
  logic [NUM_MON-1:0] flt;

  assign set_cond[MON_OV] = ov_above_i;
  assign clr_cond[MON_OV] = ov_below_rel_i;
  assign set_cond[MON_UV] = uv_below_i;
  assign clr_cond[MON_UV] = uv_above_rel_i;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    pgw_hyst_filter #(
      .FILT_CYC(FILT_CYC)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_cond[g]),
      .clr_i (clr_cond[g]),
      .flt_o (flt[g])
    );
  end

  pgw_pg_seq #(
    .DLY_CYC(DLY_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .startup_i(startup_done_i),
    .shdn_i   (fault_shdn_i),
    .fault_i  (|flt),
    .pg_n_o   (pg_n_o)
  );

  assign ov_flt_o = flt[MON_OV];
  assign uv_flt_o = flt[MON_UV];
endmodule

// File: rtl/pgw_window_mon_chk.sv
module pgw_window_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic startup_done_i,
  input logic fault_shdn_i,
  input logic ov_above_i,
  input logic ov_below_rel_i,
  input logic uv_below_i,
  input logic uv_above_rel_i,
  input logic pg_n_o,
  input logic ov_flt_o,
  input logic uv_flt_o
);
  // R2
  ov_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_flt_o) |-> $past(ov_above_i));
  // R4
  ov_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ov_flt_o) |-> $past(ov_below_rel_i));
  // R5
  uv_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_flt_o) |-> $past(uv_below_i));
  // R6
  uv_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uv_flt_o) |-> $past(uv_above_rel_i));
  // R8
  fault_blocks_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_flt_o || uv_flt_o) |-> pg_n_o);
  // R9
  shdn_blocks_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_shdn_i || !startup_done_i) |-> pg_n_o);
  // R7
  pg_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pg_n_o) |-> $past(startup_done_i && !fault_shdn_i));
endmodule

bind pgw_window_mon pgw_window_mon_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .startup_done_i(startup_done_i),
  .fault_shdn_i  (fault_shdn_i),
  .ov_above_i    (ov_above_i),
  .ov_below_rel_i(ov_below_rel_i),
  .uv_below_i    (uv_below_i),
  .uv_above_rel_i(uv_above_rel_i),
  .pg_n_o        (pg_n_o),
  .ov_flt_o      (ov_flt_o),
  .uv_flt_o      (uv_flt_o)
);

// File: tb/pgw_window_mon_tb.sv
`timescale 1ns/1ps
module pgw_window_mon_tb;
  localparam int unsigned FILT = 4;
  localparam int unsigned DLY  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic su = 1'b0, sd = 1'b0, os = 1'b0, oc = 1'b0, us = 1'b0, uc = 1'b0;
  logic pg_n, ov, uv;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgw_window_mon #(
    .CLK_PER_US (1),
    .FILT_US    (FILT),
    .PG_DELAY_US(DLY)
  ) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .startup_done_i(su),
    .fault_shdn_i  (sd),
    .ov_above_i    (os),
    .ov_below_rel_i(oc),
    .uv_below_i    (us),
    .uv_above_rel_i(uc),
    .pg_n_o        (pg_n),
    .ov_flt_o      (ov),
    .uv_flt_o      (uv)
  );

  typedef struct packed {
    logic       su, sd, os, oc, us, uc;
    logic [7:0] hold;
    logic       pg_n, ov, uv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,0, 8'd15, 1,0,0, 4'd7},  // R7 one edge early
    '{1,0,0,0,0,0, 8'd1,  0,0,0, 4'd7},  // R7 expiry edge
    '{1,0,1,0,0,0, 8'd3,  0,0,0, 4'd2},  // R2 not yet
    '{1,0,0,0,0,0, 8'd1,  0,0,0, 4'd3},  // R3 break
    '{1,0,1,0,0,0, 8'd3,  0,0,0, 4'd3},  // R3 count restarted
    '{1,0,1,0,0,0, 8'd1,  1,1,0, 4'd2},  // R2 set, pg released
    '{1,0,0,0,0,0, 8'd10, 1,1,0, 4'd4},  // R4 inside band
    '{1,0,0,1,0,0, 8'd3,  1,1,0, 4'd4},  // R4 not yet
    '{1,0,0,0,0,0, 8'd1,  1,1,0, 4'd4},  // R4 break
    '{1,0,0,1,0,0, 8'd4,  0,0,0, 4'd8},  // R8 clears, no new delay
    '{1,0,0,0,1,0, 8'd3,  0,0,0, 4'd5},  // R5 not yet
    '{1,0,0,0,1,0, 8'd1,  1,0,1, 4'd5},  // R5 set
    '{1,0,0,0,0,0, 8'd6,  1,0,1, 4'd6},  // R6 inside band
    '{1,0,0,0,0,1, 8'd2,  1,0,1, 4'd6},  // R6 partial
    '{1,0,0,0,0,0, 8'd1,  1,0,1, 4'd6},  // R6 break
    '{1,0,0,0,0,1, 8'd4,  0,0,0, 4'd8},  // R8 uv clear
    '{1,0,1,0,1,0, 8'd4,  1,1,1, 4'd8},  // R8 both faults
    '{1,0,0,1,0,0, 8'd4,  1,0,1, 4'd8},  // R8 one fault left
    '{1,0,0,0,0,1, 8'd4,  0,0,0, 4'd8}   // R8 all clear
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {pg_n,ov,uv} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, b, c, d, e, f);
    su = a; sd = b; os = c; oc = d; us = e; uc = f;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {pg_n, ov, uv}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].su, VEC[i].sd, VEC[i].os, VEC[i].oc, VEC[i].us, VEC[i].uc);
      wait_edges(int'(VEC[i].hold));
      check($sformatf("R%0d vec%0d", VEC[i].req, i), {pg_n, ov, uv},
            {VEC[i].pg_n, VEC[i].ov, VEC[i].uv});
    end

    // R9: shutdown between edges releases pg at once
    drive(1, 1, 0, 0, 0, 0);
    #1;
    check("R9 immediate", {pg_n, ov, uv}, 3'b100);
    wait_edges(1);
    drive(1, 0, 0, 0, 0, 0);
    wait_edges(DLY - 1);
    check("R9 delay restarted", {pg_n, ov, uv}, 3'b100);
    wait_edges(1);
    check("R9 delay expiry", {pg_n, ov, uv}, 3'b000);

    // R9: leaving started state
    drive(0, 0, 0, 0, 0, 0);
    #1;
    check("R9 mode exit", {pg_n, ov, uv}, 3'b100);
    wait_edges(1);

    // R10: fault during delay neither stops nor restarts it
    drive(1, 0, 0, 0, 1, 0);
    wait_edges(FILT);
    check("R10 fault in delay", {pg_n, ov, uv}, 3'b101);
    wait_edges(DLY - FILT);
    check("R10 expiry with fault", {pg_n, ov, uv}, 3'b101);
    drive(1, 0, 0, 0, 0, 1);
    wait_edges(FILT);
    check("R10 fault cleared", {pg_n, ov, uv}, 3'b000);

    // R1: asynchronous reset mid-run
    drive(1, 0, 1, 0, 0, 0);
    wait_edges(FILT);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async", {pg_n, ov, uv}, 3'b100);
    wait_edges(2);
    check("R1 held", {pg_n, ov, uv}, 3'b100);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule